// File: doc/BRIEF.md
# Interrupt coalescing counter and timer

This block thins out the interrupt traffic of a single DMA channel. Two mechanisms share one completion counter. The first is a batch counter. It counts finished descriptors down from a programmable limit and emits a batch event when the last one of the batch arrives. The second is an idle timer. Every finished descriptor restarts it from a programmable delay, and it emits a delay event when no further completion arrives before it runs out. The timer's expiry also restarts the batch from the limit, so a partial batch that has gone quiet is flushed and counting starts again from a full batch.

The limit and the delay are 8-bit values taken from the channel's control word: the limit from bits 23:16 and the delay from bits 31:24. The block itself receives them as two separate ports. A start request, raised when the channel is started, reloads the counter. A tick enable paces the timer, so the timer's resolution is set by whoever drives the tick. The live counter and timer values are brought out so that a register file can offer them for readback. Masking of the events and the register file itself lie outside this block.

Top module: `irq_coalesce`

## Requirements
- R1: After reset the counter reads 1, the timer reads 0 and neither event output is high.
- R2: A completion that is accepted while the counter is above 1 lowers the counter by exactly 1 on the next cycle (for example 255 becomes 254), and no batch event is raised.
- R3: A completion that is accepted while the counter reads 1 raises the batch event for one cycle on the next cycle and reloads the counter with the effective limit.
- R4: A limit of 0 behaves as a limit of 1. With that limit every accepted completion raises the batch event, and the counter never reads 0.
- R5: An accepted completion with a non-zero delay loads the timer with the delay on the next cycle. The load replaces any countdown already running and takes priority over a tick in the same cycle.
- R6: With no completion accepted, the timer drops by 1 on each cycle where the tick enable is high and its value is not 0. It holds its value on every other cycle.
- R7: A tick that arrives while the timer reads 1, with no accepted completion, sets the timer to 0, raises the delay event for one cycle on the next cycle and reloads the counter with the effective limit.
- R8: An accepted completion with a delay of 0 stops the timer at 0, and no delay event follows from it.
- R9: A start request reloads the counter with the effective limit on the next cycle and leaves the timer untouched. A completion in the same cycle is dropped: it raises no batch event and does not touch the timer.
- R10: While the timer reads 0 and no completion is accepted, ticks leave it at 0 and raise no delay event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Channel start request; reloads the counter |
| done_i | input | 1 | One pulse per finished descriptor |
| tick_i | input | 1 | Timer step enable |
| limit_i | input | CNT_W (8) | Batch limit, taken from control bits 23:16 |
| delay_i | input | TMR_W (8) | Idle delay in ticks, taken from control bits 31:24 |
| batch_evt_o | output | 1 | One-cycle batch-complete event |
| delay_evt_o | output | 1 | One-cycle idle-timeout event |
| batch_cnt_o | output | CNT_W (8) | Live counter value |
| delay_cnt_o | output | TMR_W (8) | Live timer value |

## Verification
The bench aims first at the collision cycles, where two inputs arrive together:
- A completion together with a tick. A design that let the tick win would fall one step short of the delay.
- A start request together with a completion. A design that counted the completion would lose one descriptor from the next batch, or raise a spurious batch event.
- A start request together with a running timer. A design that cleared the timer on start would swallow the pending delay event.

The limit of 0 is driven. A design that took it literally would wrap the counter to 255 and hold back the batch event for 255 more completions.

A delay of 0 is applied while the timer is running. A design that only skipped the reload would let the old countdown expire anyway.

A tick on an idle timer is also driven. A design that decremented it would wrap to 255 or raise a false delay event.

// File: rtl/icq_pkg.sv
package icq_pkg;

  // What the batch counter does in a given cycle.
  typedef enum logic [1:0] {
    CNT_HOLD   = 2'd0,
    CNT_STEP   = 2'd1,
    CNT_RELOAD = 2'd2,
    CNT_FIRE   = 2'd3
  } cnt_act_e;

  // What the idle timer does in a given cycle.
  typedef enum logic [1:0] {
    TMR_HOLD = 2'd0,
    TMR_LOAD = 2'd1,
    TMR_STEP = 2'd2,
    TMR_LAST = 2'd3
  } tmr_act_e;

endpackage

// File: rtl/icq_batch_counter.sv
module icq_batch_counter
  import icq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload_i,
  input  logic             count_i,
  input  logic             expire_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             fire_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // A limit of zero is read as one, so the counter never reaches zero.
  function automatic logic [CNT_W-1:0] eff_limit(input logic [CNT_W-1:0] lim);
    return (lim == '0) ? ONE : lim;
  endfunction

  // Start and timeout reload the counter. Otherwise a completion either
  // ends the batch or takes one step down.
  function automatic cnt_act_e pick_act(input logic rl, input logic ct,
                                        input logic ex,
                                        input logic [CNT_W-1:0] cur);
    if (rl || ex)        return CNT_RELOAD;
    else if (!ct)        return CNT_HOLD;
    else if (cur <= ONE) return CNT_FIRE;
    else                 return CNT_STEP;
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit_eff;
  cnt_act_e         act;
  logic             fire_q;

  assign limit_eff = eff_limit(limit_i);
  assign act       = pick_act(reload_i, count_i, expire_i, cnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= ONE;
      fire_q <= 1'b0;
    end else begin
      fire_q <= (act == CNT_FIRE);
      unique case (act)
        CNT_STEP:             cnt_q <= cnt_q - ONE;
        CNT_RELOAD, CNT_FIRE: cnt_q <= limit_eff;
        default:              cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_o  = cnt_q;
  assign fire_o = fire_q;

  // R4: the counter never reads zero
  a_r4_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != '0);

  // R2: a step lowers the count by one and raises no event
  a_r2_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (count_i && !reload_i && !expire_i && cnt_q > ONE)
      |=> (cnt_q == $past(cnt_q) - ONE) && !fire_o);

  // R3: the last completion of a batch fires and reloads
  a_r3_fire_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (count_i && !reload_i && !expire_i && cnt_q == ONE)
      |=> fire_o && (cnt_q == $past(limit_eff)));

  // R9: a start request reloads and never fires
  a_r9_start_reload: assert property (@(posedge clk) disable iff (!rst_n)
    reload_i |=> (cnt_q == $past(limit_eff)) && !fire_o);

  // R7: a timeout reloads the counter
  a_r7_expire_reload: assert property (@(posedge clk) disable iff (!rst_n)
    expire_i |=> cnt_q == $past(limit_eff));

endmodule

// File: rtl/icq_delay_timer.sv
module icq_delay_timer
  import icq_pkg::*;
#(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [TMR_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic [TMR_W-1:0] tmr_o,
  output logic             expire_o,
  output logic             evt_o
);

  localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

  // A load wins over a tick. A timer at zero is stopped.
  function automatic tmr_act_e pick_act(input logic ld, input logic tk,
                                        input logic [TMR_W-1:0] cur);
    if (ld)               return TMR_LOAD;
    else if (!tk)         return TMR_HOLD;
    else if (cur == '0)   return TMR_HOLD;
    else if (cur == ONE)  return TMR_LAST;
    else                  return TMR_STEP;
  endfunction

  logic [TMR_W-1:0] tmr_q;
  tmr_act_e         act;
  logic             evt_q;

  assign act = pick_act(load_i, tick_i, tmr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr_q <= '0;
      evt_q <= 1'b0;
    end else begin
      evt_q <= (act == TMR_LAST);
      unique case (act)
        TMR_LOAD:           tmr_q <= load_val_i;
        TMR_STEP, TMR_LAST: tmr_q <= tmr_q - ONE;
        default:            tmr_q <= tmr_q;
      endcase
    end
  end

  assign tmr_o    = tmr_q;
  assign expire_o = (act == TMR_LAST);
  assign evt_o    = evt_q;

  // R5: a load takes the new value, whatever was running
  a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> tmr_q == $past(load_val_i));

  // R6: without a tick or a load the timer holds
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !tick_i) |=> $stable(tmr_q));

  // R6: a tick on a running timer takes one step
  a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && tick_i && tmr_q != '0) |=> tmr_q == $past(tmr_q) - ONE);

  // R7: the delay event only comes with an empty timer
  a_r7_evt_empty: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |-> tmr_q == '0);

  // R10: an idle timer stays idle and quiet
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_q == '0 && !load_i) |=> (tmr_q == '0) && !evt_o);

endmodule

// File: rtl/irq_coalesce.sv
module irq_coalesce #(
  parameter int CNT_W = 8,
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             done_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic [TMR_W-1:0] delay_i,
  output logic             batch_evt_o,
  output logic             delay_evt_o,
  output logic [CNT_W-1:0] batch_cnt_o,
  output logic [TMR_W-1:0] delay_cnt_o
);

  // Named internal events, brought out for the assertions.
  logic done_acc;   // completion that is counted (no start in the same cycle)
  logic tmr_exp;    // the timer runs out in this cycle

  assign done_acc = done_i && !start_i;

  icq_batch_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .reload_i (start_i),
    .count_i  (done_acc),
    .expire_i (tmr_exp),
    .limit_i  (limit_i),
    .cnt_o    (batch_cnt_o),
    .fire_o   (batch_evt_o)
  );

  icq_delay_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (done_acc),
    .load_val_i (delay_i),
    .tick_i     (tick_i),
    .tmr_o      (delay_cnt_o),
    .expire_o   (tmr_exp),
    .evt_o      (delay_evt_o)
  );

  // R8: a completion with a zero delay leaves the timer stopped
  a_r8_zero_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (done_acc && delay_i == '0) |=> (delay_cnt_o == '0) && !delay_evt_o);

  // R9: a completion dropped by a start request does not touch the timer
  a_r9_drop_done: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !tick_i) |=> $stable(delay_cnt_o));

  // R1: right after reset everything is at rest
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (batch_cnt_o == CNT_W'(1)) && (delay_cnt_o == '0)
               && !batch_evt_o && !delay_evt_o);

endmodule

// File: tb/irq_coalesce_test.sv
module irq_coalesce_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i, done_i, tick_i;
  logic [7:0] limit_i, delay_i;
  logic       batch_evt_o, delay_evt_o;
  logic [7:0] batch_cnt_o, delay_cnt_o;

  int n_checks = 0;
  int n_fails  = 0;

  always #5 clk = ~clk;

  irq_coalesce uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .done_i      (done_i),
    .tick_i      (tick_i),
    .limit_i     (limit_i),
    .delay_i     (delay_i),
    .batch_evt_o (batch_evt_o),
    .delay_evt_o (delay_evt_o),
    .batch_cnt_o (batch_cnt_o),
    .delay_cnt_o (delay_cnt_o)
  );

  typedef struct packed {
    logic       st;
    logic       dn;
    logic       tk;
    logic [7:0] lim;
    logic [7:0] dly;
    logic [7:0] ecnt;
    logic [7:0] etmr;
    logic       eb;
    logic       ed;
  } row_t;

  localparam int NROW = 22;

  // Inputs for one cycle, then the outputs expected after that edge.
  localparam row_t TBL [0:NROW-1] = '{
    '{1'b1,1'b0,1'b0, 8'd3, 8'd4, 8'd3, 8'd0, 1'b0,1'b0}, // 0  R9 start loads limit
    '{1'b0,1'b1,1'b0, 8'd3, 8'd4, 8'd2, 8'd4, 1'b0,1'b0}, // 1  R2 R5
    '{1'b0,1'b0,1'b1, 8'd3, 8'd4, 8'd2, 8'd3, 1'b0,1'b0}, // 2  R6 tick
    '{1'b0,1'b0,1'b0, 8'd3, 8'd4, 8'd2, 8'd3, 1'b0,1'b0}, // 3  R6 hold
    '{1'b0,1'b1,1'b1, 8'd3, 8'd4, 8'd1, 8'd4, 1'b0,1'b0}, // 4  R5 load beats tick
    '{1'b0,1'b1,1'b0, 8'd3, 8'd4, 8'd3, 8'd4, 1'b1,1'b0}, // 5  R3 batch fires
    '{1'b0,1'b1,1'b0, 8'd3, 8'd4, 8'd2, 8'd4, 1'b0,1'b0}, // 6  R2
    '{1'b0,1'b0,1'b1, 8'd3, 8'd4, 8'd2, 8'd3, 1'b0,1'b0}, // 7  R6
    '{1'b0,1'b0,1'b1, 8'd3, 8'd4, 8'd2, 8'd2, 1'b0,1'b0}, // 8  R6
    '{1'b0,1'b0,1'b1, 8'd3, 8'd4, 8'd2, 8'd1, 1'b0,1'b0}, // 9  R6
    '{1'b0,1'b0,1'b1, 8'd3, 8'd4, 8'd3, 8'd0, 1'b0,1'b1}, // 10 R7 timeout reloads
    '{1'b0,1'b0,1'b1, 8'd3, 8'd4, 8'd3, 8'd0, 1'b0,1'b0}, // 11 R10 idle tick
    '{1'b1,1'b0,1'b0, 8'd0, 8'd0, 8'd1, 8'd0, 1'b0,1'b0}, // 12 R4 zero limit as one
    '{1'b0,1'b1,1'b0, 8'd0, 8'd0, 8'd1, 8'd0, 1'b1,1'b0}, // 13 R4 R8
    '{1'b0,1'b1,1'b0, 8'd0, 8'd0, 8'd1, 8'd0, 1'b1,1'b0}, // 14 R4 every completion
    '{1'b0,1'b1,1'b0, 8'd5, 8'd2, 8'd5, 8'd2, 1'b1,1'b0}, // 15 R3 new limit
    '{1'b0,1'b1,1'b0, 8'd5, 8'd0, 8'd4, 8'd0, 1'b0,1'b0}, // 16 R8 zero delay stops
    '{1'b0,1'b0,1'b1, 8'd5, 8'd0, 8'd4, 8'd0, 1'b0,1'b0}, // 17 R8 no late event
    '{1'b1,1'b1,1'b0, 8'd5, 8'd2, 8'd5, 8'd0, 1'b0,1'b0}, // 18 R9 completion dropped
    '{1'b0,1'b1,1'b0, 8'd5, 8'd2, 8'd4, 8'd2, 1'b0,1'b0}, // 19 R2 R5
    '{1'b1,1'b0,1'b1, 8'd5, 8'd2, 8'd5, 8'd1, 1'b0,1'b0}, // 20 R9 timer untouched
    '{1'b0,1'b0,1'b1, 8'd5, 8'd2, 8'd5, 8'd0, 1'b0,1'b1}  // 21 R7
  };

  localparam int RQ [0:NROW-1] = '{9,2,6,6,5,3,2,6,6,6,7,10,4,4,4,3,8,8,9,2,9,7};

  task automatic show_summary();
    $display("  %0d/%0d checks passed", n_checks - n_fails, n_checks);
  endtask

  task automatic chk(input string tag, input logic [17:0] act,
                     input logic [17:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s cnt/tmr/b/d actual=%h/%h/%b/%b expected=%h/%h/%b/%b",
               tag, act[17:10], act[9:2], act[1], act[0],
               exp[17:10], exp[9:2], exp[1], exp[0]);
    end
  endtask

  function automatic logic [17:0] outs();
    return {batch_cnt_o, delay_cnt_o, batch_evt_o, delay_evt_o};
  endfunction

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired");
    show_summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; done_i = 1'b0; tick_i = 1'b0;
    limit_i = 8'd1; delay_i = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1 reset", outs(), {8'd1, 8'd0, 1'b0, 1'b0});

    for (int i = 0; i < NROW; i++) begin
      start_i = TBL[i].st; done_i = TBL[i].dn; tick_i = TBL[i].tk;
      limit_i = TBL[i].lim; delay_i = TBL[i].dly;
      @(negedge clk);
      chk($sformatf("row %0d R%0d", i, RQ[i]), outs(),
          {TBL[i].ecnt, TBL[i].etmr, TBL[i].eb, TBL[i].ed});
    end

    // R2: the widest limit steps down by one
    start_i = 1'b1; done_i = 1'b0; tick_i = 1'b0; limit_i = 8'd255; delay_i = 8'd9;
    @(negedge clk);
    chk("R9 start limit 255", outs(), {8'd255, 8'd0, 1'b0, 1'b0});
    start_i = 1'b0; done_i = 1'b1;
    @(negedge clk);
    chk("R2 255 to 254", outs(), {8'd254, 8'd9, 1'b0, 1'b0});
    done_i = 1'b0; tick_i = 1'b1;
    @(negedge clk);
    chk("R6 9 to 8", outs(), {8'd254, 8'd8, 1'b0, 1'b0});

    // R1: reset in the middle of a run
    tick_i = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset mid-run", outs(), {8'd1, 8'd0, 1'b0, 1'b0});
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", outs(), {8'd1, 8'd0, 1'b0, 1'b0});

    show_summary();
    $finish;
  end

endmodule